// File: doc/BRIEF.md
# Host Root Port Bring-Up Sequencer

This block takes one host root port from power-off to an enabled link. Software writes a control word to switch port power on and to request a bus reset. The block watches an already debounced attach indication from the line-state logic and counts it only while port power is on. A new attach, and later a detach, each set a sticky connection event. While software holds the reset request, the block drives the bus reset output. A cycle counter, set from the clock frequency in kHz and the minimum time in ms, keeps that output asserted for at least the minimum time, even when software drops the request early.

When the reset output drops and a device is still attached, the port turns enabled. The block then latches the two-bit speed code presented by the line logic and raises a sticky enable-change event. The speed output reads zero while the port is not enabled. A detach or power-off disables the port, wipes the speed and sets the connection event again. A new reset start also disables the port. Both events are cleared by writing one to their clear bits. The interrupt output combines them, gated by a local enable held in the control word and a chip-level global enable input.

Top module: `hport_ctrl`

## Requirements
- R1: After synchronous reset, all outputs (port power, bus reset, enabled, speed, both events, interrupt) are 0.
- R2: A write with `ctl_we` high stores control-word bit 0 (port power) and bit 2 (interrupt enable). Port power appears on `port_pwr_o` one cycle after the write.
- R3: While port power is off, changes on `attach_i` set no event and cannot enable the port.
- R4: One cycle after `attach_i` rises with port power on, `conn_evt_o` is 1. A later detach, whether `attach_i` falls or power goes off, sets it again.
- R5: A write with bit 4 set clears `conn_evt_o`, and a write with bit 5 set clears `en_evt_o`. Writing 0 to these bits has no effect. A set condition in the same cycle as a clear wins, and the event stays 1.
- R6: Writing 1 to bit 1 asserts `bus_rst_o` one cycle later. It stays asserted as long as bit 1 is 1 and for at least CLK_KHZ*RST_MS cycles from the start, even if bit 1 is cleared sooner.
- R7: In the cycle `bus_rst_o` drops with a device attached under power, `port_en_o` becomes 1, the `dev_speed_i` value is latched, and `en_evt_o` is set. If no device is attached at that point, the port stays disabled.
- R8: `speed_o` shows the latched code only while `port_en_o` is 1, and reads 0 otherwise.
- R9: A detach or power-off clears `port_en_o` and the latched speed one cycle later, and sets `en_evt_o` if the port was enabled.
- R10: Starting a new bus reset while the port is enabled clears `port_en_o` and sets `en_evt_o`.
- R11: `irq_o` equals `glb_ie_i` AND the interrupt enable bit AND (`conn_evt_o` OR `en_evt_o`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: bit0 power, bit1 reset request, bit2 int enable, bit4 clear connection event, bit5 clear enable event |
| glb_ie_i | input | 1 | Chip-level global interrupt enable |
| attach_i | input | 1 | Debounced device-present indication |
| dev_speed_i | input | 2 | Speed code from line logic |
| port_pwr_o | output | 1 | Port power drive |
| bus_rst_o | output | 1 | Bus reset drive |
| port_en_o | output | 1 | Port enabled status |
| speed_o | output | 2 | Latched speed, 0 when not enabled |
| conn_evt_o | output | 1 | Sticky connection-change event |
| en_evt_o | output | 1 | Sticky enable-change event |
| irq_o | output | 1 | Port interrupt |

## Verification
The bench clears the reset request a few cycles after setting it. A design that trusts software timing would drop the bus reset early and enable the port too soon. It detaches the device during reset so that the release leaves the port disabled, and it switches power off while enabled, which a careless design would leave enabled with a stale speed. It also clears an event in the same cycle that an attach change sets it, and it restarts reset on an enabled port. A design that got the priority or the disable on restart wrong would show a missing event or a stuck enable.

// File: rtl/hport_pkg.sv
package hport_pkg;

    typedef enum logic [1:0] {
        SPD_CODE0 = 2'd0,
        SPD_CODE1 = 2'd1,
        SPD_CODE2 = 2'd2,
        SPD_CODE3 = 2'd3
    } hport_speed_e;

    typedef struct packed {
        logic [1:0] spare;
        logic       clr_en_evt;
        logic       clr_conn_evt;
        logic       spare3;
        logic       int_en;
        logic       rst_req;
        logic       pwr;
    } hport_ctl_t;

    typedef struct packed {
        logic conn_set;
        logic en_set;
        logic conn_clr;
        logic en_clr;
    } hport_evt_req_t;

    function automatic hport_ctl_t hport_decode(input logic [7:0] w);
        return hport_ctl_t'(w);
    endfunction

    function automatic int unsigned hport_min_cycles(input int unsigned khz,
                                                     input int unsigned ms);
        return (khz * ms == 0) ? 1 : khz * ms;
    endfunction

endpackage

// File: rtl/hport_rst_timer.sv
module hport_rst_timer #(
    parameter int unsigned MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic req_bit,
    output logic rst_o,
    output logic start_o,
    output logic release_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYC);

    logic          req_q, req_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rst_q, rst_d;

    always_comb begin
        req_d   = we ? req_bit : req_q;
        start_o = req_d & ~rst_q;
        if (start_o)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
        rst_d     = req_d | (cnt_d != '0);
        release_o = rst_q & ~rst_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cnt_q <= '0;
            rst_q <= 1'b0;
        end else begin
            req_q <= req_d;
            cnt_q <= cnt_d;
            rst_q <= rst_d;
        end
    end

    assign rst_o = rst_q;

    // run-length counter used only by the check below
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!rst_q)
            run_q <= '0;
        else if (run_q != LOAD)
            run_q <= run_q + 1'b1;
    end

    // R6
    rst_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_q) |-> ($past(run_q) + 1'b1 >= LOAD) || ($past(run_q) == LOAD));

    // R6
    rst_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> rst_q);

endmodule

// File: rtl/hport_link.sv
module hport_link
    import hport_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_q,
    input  logic         attach_i,
    input  hport_speed_e dev_speed_i,
    input  logic         start_i,
    input  logic         release_i,
    output logic         att_chg_o,
    output logic         en_o,
    output logic         en_chg_o,
    output hport_speed_e spd_o
);
    logic         att_q, eff;
    logic         rise, fall;
    logic         en_q, en_d;
    hport_speed_e spd_q, spd_d;

    always_comb begin
        eff  = pwr_q & attach_i;
        rise = eff & ~att_q;
        fall = ~eff & att_q;
        en_d  = en_q;
        spd_d = spd_q;
        if (fall) begin
            en_d  = 1'b0;
            spd_d = SPD_CODE0;
        end else if (start_i) begin
            en_d = 1'b0;
        end else if (release_i && eff) begin
            en_d  = 1'b1;
            spd_d = dev_speed_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            att_q <= 1'b0;
            en_q  <= 1'b0;
            spd_q <= SPD_CODE0;
        end else begin
            att_q <= eff;
            en_q  <= en_d;
            spd_q <= spd_d;
        end
    end

    assign att_chg_o = rise | fall;
    assign en_chg_o  = en_d ^ en_q;
    assign en_o      = en_q;
    assign spd_o     = en_q ? spd_q : SPD_CODE0;

    // R9
    unpowered_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_q |=> !en_q);

    // R3
    no_attach_unpowered_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_q |=> !att_q);

endmodule

// File: rtl/hport_evt.sv
module hport_evt
    import hport_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  hport_evt_req_t req,
    input  logic           int_en,
    input  logic           glb_ie,
    output logic           conn_evt_o,
    output logic           en_evt_o,
    output logic           irq_o
);
    logic conn_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            conn_q <= req.conn_set | (conn_q & ~req.conn_clr);
            en_q   <= req.en_set   | (en_q   & ~req.en_clr);
        end
    end

    assign conn_evt_o = conn_q;
    assign en_evt_o   = en_q;
    assign irq_o      = glb_ie & int_en & (conn_q | en_q);

    // R5
    conn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (conn_q && !req.conn_clr) |=> conn_q);

    // R5
    en_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req.en_set |=> en_q);

endmodule

// File: rtl/hport_ctrl.sv
module hport_ctrl
    import hport_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 250000,
    parameter int unsigned RST_MS  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       glb_ie_i,
    input  logic       attach_i,
    input  logic [1:0] dev_speed_i,
    output logic       port_pwr_o,
    output logic       bus_rst_o,
    output logic       port_en_o,
    output logic [1:0] speed_o,
    output logic       conn_evt_o,
    output logic       en_evt_o,
    output logic       irq_o
);
    localparam int unsigned MIN_CYC = hport_min_cycles(CLK_KHZ, RST_MS);

    hport_ctl_t     ctl;
    logic           pwr_q, ie_q;
    logic           rst_start, rst_release;
    logic           att_chg, en_chg;
    hport_speed_e   spd;
    hport_evt_req_t ereq;

    assign ctl = hport_decode(ctl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (ctl_we) begin
            pwr_q <= ctl.pwr;
            ie_q  <= ctl.int_en;
        end
    end

    hport_rst_timer #(.MIN_CYC(MIN_CYC)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .we        (ctl_we),
        .req_bit   (ctl.rst_req),
        .rst_o     (bus_rst_o),
        .start_o   (rst_start),
        .release_o (rst_release)
    );

    hport_link u_link (
        .clk         (clk),
        .rst         (rst),
        .pwr_q       (pwr_q),
        .attach_i    (attach_i),
        .dev_speed_i (hport_speed_e'(dev_speed_i)),
        .start_i     (rst_start),
        .release_i   (rst_release),
        .att_chg_o   (att_chg),
        .en_o        (port_en_o),
        .en_chg_o    (en_chg),
        .spd_o       (spd)
    );

    always_comb begin
        ereq.conn_set = att_chg;
        ereq.en_set   = en_chg;
        ereq.conn_clr = ctl_we & ctl.clr_conn_evt;
        ereq.en_clr   = ctl_we & ctl.clr_en_evt;
    end

    hport_evt u_evt (
        .clk        (clk),
        .rst        (rst),
        .req        (ereq),
        .int_en     (ie_q),
        .glb_ie     (glb_ie_i),
        .conn_evt_o (conn_evt_o),
        .en_evt_o   (en_evt_o),
        .irq_o      (irq_o)
    );

    assign port_pwr_o = pwr_q;
    assign speed_o    = spd;

    // R7
    en_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(port_en_o) |-> $past(bus_rst_o) && !bus_rst_o);

    // R8
    speed_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en_o |-> speed_o == 2'd0);

    // R10
    en_low_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rst_o) |-> !port_en_o);

    // R11
    irq_needs_global_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> glb_ie_i && (conn_evt_o || en_evt_o));

endmodule

// File: tb/sim_hport_ctrl.sv
`timescale 1ns/1ps
module sim_hport_ctrl;
    localparam int KHZ = 3;
    localparam int MS  = 10;
    localparam int MINC = KHZ * MS;

    logic clk = 0, rst = 1;
    logic ctl_we = 0;
    logic [7:0] ctl_wdata = 0;
    logic glb_ie_i = 0, attach_i = 0;
    logic [1:0] dev_speed_i = 0;
    logic port_pwr_o, bus_rst_o, port_en_o, conn_evt_o, en_evt_o, irq_o;
    logic [1:0] speed_o;

    always #2 clk = ~clk;

    hport_ctrl #(.CLK_KHZ(KHZ), .RST_MS(MS)) u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .glb_ie_i(glb_ie_i), .attach_i(attach_i), .dev_speed_i(dev_speed_i),
        .port_pwr_o(port_pwr_o), .bus_rst_o(bus_rst_o), .port_en_o(port_en_o),
        .speed_o(speed_o), .conn_evt_o(conn_evt_o), .en_evt_o(en_evt_o),
        .irq_o(irq_o));

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: deadline-based reset hold, flags per cycle
    int  cyc = 0;
    int  deadline = -1;
    bit  m_pwr, m_req, m_ie, m_att, m_rst, m_en, m_ce, m_ee;
    int  m_spd;

    always @(posedge clk) begin
        bit n_pwr, n_req, n_ie, eff, chg, n_rst, rel, start, n_en;
        if (rst) begin
            m_pwr = 0; m_req = 0; m_ie = 0; m_att = 0; m_rst = 0;
            m_en = 0; m_ce = 0; m_ee = 0; m_spd = 0; deadline = -1;
        end else begin
            n_pwr = ctl_we ? ctl_wdata[0] : m_pwr;
            n_req = ctl_we ? ctl_wdata[1] : m_req;
            n_ie  = ctl_we ? ctl_wdata[2] : m_ie;
            eff   = m_pwr && attach_i;
            chg   = eff != m_att;
            start = n_req && !m_rst;
            if (start) deadline = cyc + MINC;
            n_rst = n_req || (cyc < deadline);
            rel   = m_rst && !n_rst;
            n_en  = m_en;
            if (m_att && !eff) begin n_en = 0; m_spd = 0; end
            else if (start) n_en = 0;
            else if (rel && eff) begin n_en = 1; m_spd = dev_speed_i; end
            if (chg) m_ce = 1; else if (ctl_we && ctl_wdata[4]) m_ce = 0;
            if (n_en != m_en) m_ee = 1; else if (ctl_we && ctl_wdata[5]) m_ee = 0;
            m_pwr = n_pwr; m_req = n_req; m_ie = n_ie; m_att = eff;
            m_rst = n_rst; m_en = n_en;
        end
        cyc++;
    end

    always @(negedge clk) if (!rst) begin
        chk(port_pwr_o == m_pwr, "R2 power", port_pwr_o, m_pwr);
        chk(bus_rst_o == m_rst, "R6 bus reset", bus_rst_o, m_rst);
        chk(port_en_o == m_en, "R7 enabled", port_en_o, m_en);
        chk(int'(speed_o) == (m_en ? m_spd : 0), "R8 speed", speed_o, m_en ? m_spd : 0);
        chk(conn_evt_o == m_ce, "R4 conn event", conn_evt_o, m_ce);
        chk(en_evt_o == m_ee, "R9 enable event", en_evt_o, m_ee);
        chk(irq_o == (glb_ie_i && m_ie && (m_ce || m_ee)), "R11 irq", irq_o,
            glb_ie_i && m_ie && (m_ce || m_ee));
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_we = 1; ctl_wdata = d; tick(); ctl_we = 0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        #1;
        // R1
        chk({port_pwr_o, bus_rst_o, port_en_o, speed_o, conn_evt_o, en_evt_o, irq_o} == 0,
            "R1 reset state", 0, 0);
        tick();
        // R3: attach without power
        attach_i = 1; tick(3);
        chk(conn_evt_o == 0, "R3 unpowered attach", conn_evt_o, 0);
        wr(8'h02); tick(MINC + 2);
        chk(port_en_o == 0, "R3 no enable unpowered", port_en_o, 0);
        wr(8'h00); tick(MINC + 2);
        attach_i = 0; tick();
        // R2 power on with int enable; then attach
        glb_ie_i = 1;
        wr(8'h05);
        chk(port_pwr_o == 1, "R2 power on", port_pwr_o, 1);
        attach_i = 1; tick();
        chk(conn_evt_o == 1, "R4 attach event", conn_evt_o, 1);
        chk(irq_o == 1, "R11 irq on attach", irq_o, 1);
        // R5: write 0 to clear bits does nothing, then clear
        wr(8'h05); chk(conn_evt_o == 1, "R5 zero write keeps", conn_evt_o, 1);
        wr(8'h15); chk(conn_evt_o == 0, "R5 clear", conn_evt_o, 0);
        // R6: short request, held to minimum
        dev_speed_i = 2'd2;
        wr(8'h07); chk(bus_rst_o == 1, "R6 reset asserted", bus_rst_o, 1);
        tick(3); wr(8'h05);
        tick(MINC - 6);
        chk(bus_rst_o == 1, "R6 held to minimum", bus_rst_o, 1);
        tick(4);
        chk(port_en_o == 1, "R7 enabled after release", port_en_o, 1);
        chk(speed_o == 2'd2, "R7 speed latched", speed_o, 2);
        chk(en_evt_o == 1, "R7 enable event", en_evt_o, 1);
        dev_speed_i = 2'd1; tick();
        chk(speed_o == 2'd2, "R8 speed stable", speed_o, 2);
        wr(8'h25);
        // R10: restart reset on enabled port, long software hold
        wr(8'h07); chk(port_en_o == 0, "R10 disabled on restart", port_en_o, 0);
        chk(en_evt_o == 1, "R10 enable event", en_evt_o, 1);
        tick(MINC + 10);
        chk(bus_rst_o == 1, "R6 held while requested", bus_rst_o, 1);
        wr(8'h35); tick();
        chk(port_en_o == 1, "R7 re-enabled", port_en_o, 1);
        chk(speed_o == 2'd1, "R7 new speed", speed_o, 1);
        // R5 set wins over clear: detach in the clearing cycle
        wr(8'h35);
        attach_i = 0; ctl_we = 1; ctl_wdata = 8'h35; tick(); ctl_we = 0;
        chk(conn_evt_o == 1, "R5 set wins", conn_evt_o, 1);
        chk(port_en_o == 0, "R9 detach disables", port_en_o, 0);
        chk(speed_o == 0, "R9 speed cleared", speed_o, 0);
        // detach during reset: stays disabled
        attach_i = 1; tick(2); wr(8'h35);
        wr(8'h07); tick(4); attach_i = 0; wr(8'h05); tick(MINC + 2);
        chk(port_en_o == 0, "R7 no enable after detach in reset", port_en_o, 0);
        // R9 power off while enabled
        attach_i = 1; tick(); wr(8'h07); wr(8'h05); tick(MINC + 2);
        chk(port_en_o == 1, "R7 enabled again", port_en_o, 1);
        wr(8'h30);
        wr(8'h00); tick();
        chk(port_en_o == 0, "R9 power off disables", port_en_o, 0);
        chk(conn_evt_o == 1 && en_evt_o == 1, "R9 events on power off", conn_evt_o, 1);
        chk(irq_o == 0, "R11 irq masked by local enable", irq_o, 0);
        wr(8'h04); glb_ie_i = 0; #1;
        chk(irq_o == 0, "R11 irq masked by global", irq_o, 0);
        tick(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule